// File: doc/BRIEF.md
# Step/Direction Pulse Output Sequencer

This block is the output stage of one axis of a step/direction motion controller. A host issues commands through a one-cycle write strobe with a two-bit opcode. The commands are: start a move, arm the hold gate, release held moves, and abort. A move is described by plain inputs, which are a pulse count, a period in clock cycles, a direction and an output mode. The sequencer emits that many pulses and raises a busy flag while a move is in progress. Direction framing is tight: the direction output is set one cycle before the first pulse and stays until one cycle after the last.

Pulses can leave on separate plus and minus lines, or as a single step line with a direction line. Four asynchronous safety inputs can cut a move short: emergency, alarm, and the two travel limits. The limits act only when limit halting is enabled, and only the limit facing the direction of travel counts. A safety input takes effect only after it has been seen high on two consecutive clock samples. An abort never chops a pulse: a pulse that is high runs to its full width, and then the move ends.

Top module: `step_pulse_seq`

## Requirements
- R1: A write with `host_wr`=1 and `host_op`=0 (drive) is accepted when the block is idle, `count_in` is nonzero and no qualified halt source is active for `dir_in`. `busy` is 1 in the cycle after the write edge (the setup cycle).
- R2: Without hold, the first pulse is high in the second cycle after the write edge, which is two cycles after the edge and inside the four-cycle bound.
- R3: The effective period is P = max(`period_in`, 4). Each pulse is high for floor(P/2) cycles and low for P minus that before the next pulse.
- R4: A move emits exactly `count_in` pulses. `busy` stays 1 for one tail cycle after the last pulse falls, then drops. A drive with `count_in`=0 is ignored.
- R5: With `mode_in`=0, pulses appear on `pls_plus` when `dir_in`=0 and on `pls_minus` when `dir_in`=1. The other pulse line and `pls_step` stay 0.
- R6: With `mode_in`=1, pulses appear on `pls_step` and both `pls_plus` and `pls_minus` stay 0. `dir_out` equals the latched direction (1 = negative) from the setup cycle through the tail cycle.
- R7: Opcode 1 arms hold and opcode 2 releases it. A drive accepted while hold is armed keeps `busy`=1 with no pulses until a release write. The first pulse then appears two cycles after the release edge.
- R8: A drive write while `busy`=1 is ignored. The running move keeps its count, period and direction.
- R9: Opcode 3 (abort) lets a high pulse finish its full width, adds one tail cycle with `busy`=1, and then goes idle. If no pulse is high, `busy` drops in the cycle after the abort edge.
- R10: `emg_in` and `alarm_in` halt any move. `lim_pos_in` and `lim_neg_in` halt a positive or a negative move only when `lim_halt_en`=1. A source acts only when it is high at two consecutive edges, and a one-cycle high is ignored. A source that goes high before edges j and j+1 takes effect at edge j+2, with the same completion rule as R9.
- R11: A drive write is ignored while a qualified halt source for its direction is active.
- R12: While `rst_n`=0 at a clock edge, every output is driven to 0, hold is disarmed and the move counters are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | One-cycle command write strobe |
| host_op | input | 2 | Opcode: 0 drive, 1 hold, 2 release, 3 abort |
| dir_in | input | 1 | Move direction, 1 = negative |
| mode_in | input | 1 | 0 = plus/minus lines, 1 = step + direction |
| period_in | input | PW | Pulse period in cycles (minimum 4) |
| count_in | input | CW | Number of pulses in the move |
| emg_in | input | 1 | Emergency halt source |
| alarm_in | input | 1 | Alarm halt source |
| lim_pos_in | input | 1 | Positive travel limit |
| lim_neg_in | input | 1 | Negative travel limit |
| lim_halt_en | input | 1 | Enables limit inputs as halt sources |
| pls_plus | output | 1 | Plus pulse line (mode 0) |
| pls_minus | output | 1 | Minus pulse line (mode 0) |
| pls_step | output | 1 | Step pulse line (mode 1) |
| dir_out | output | 1 | Direction line |
| busy | output | 1 | Move in progress |

## Verification
The hardest case to reach is a halt that lands at a chosen phase of the pulse train. It must be tested while a pulse is high, while the output is low between pulses, and in the cycle where a high phase ends anyway. The halt arrives through the two-sample qualifier, so an input change reaches the sequencer two edges late. The bench places every abort write and every safety-input edge at an exact sample offset from the drive edge, and it accounts for the qualifier's two-edge delay. It then cuts its own precomputed pulse trace at that offset using the completion rule. This covers the high-phase, low-phase and phase-end cases for the abort command, the emergency input and the positive limit. A one-cycle glitch and a limit facing away from the travel are also applied, and the trace must come out unchanged.

// File: rtl/step_pulse_pkg.sv
package step_pulse_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_SETUP,
    ST_HIGH,
    ST_LOW,
    ST_TAIL
  } seq_state_e;

  typedef enum logic [1:0] {
    OP_DRIVE   = 2'd0,
    OP_HOLD    = 2'd1,
    OP_RELEASE = 2'd2,
    OP_ABORT   = 2'd3
  } host_op_e;

  localparam int unsigned MIN_PERIOD = 4;

  // Period after clamping to the shortest legal value.
  function automatic int unsigned eff_period(int unsigned p);
    return (p < MIN_PERIOD) ? MIN_PERIOD : p;
  endfunction

  // Cycles spent high per pulse: half the period, rounded down.
  function automatic int unsigned high_len(int unsigned p);
    return eff_period(p) / 2;
  endfunction

  // Cycles spent low per pulse: the remainder of the period.
  function automatic int unsigned low_len(int unsigned p);
    return eff_period(p) - high_len(p);
  endfunction

endpackage

// File: rtl/stop_qual.sv
module stop_qual #(
  parameter int unsigned NSRC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] raw,
  output logic [NSRC-1:0] qual
);

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic samp0, samp1;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        samp0 <= 1'b0;
        samp1 <= 1'b0;
      end else begin
        samp0 <= raw[g];
        samp1 <= samp0;
      end
    end
    // Active only after two consecutive high samples.
    assign qual[g] = samp0 & samp1;
  end

endmodule

// File: rtl/pulse_engine.sv
module pulse_engine
  import step_pulse_pkg::*;
#(
  parameter int unsigned PW = 16,
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_drive,
  input  logic          op_hold,
  input  logic          op_release,
  input  logic          op_abort,
  input  logic          dir_in,
  input  logic          mode_in,
  input  logic [PW-1:0] period_in,
  input  logic [CW-1:0] count_in,
  input  logic          halt_pos,
  input  logic          halt_neg,
  output logic          pulse_on,
  output logic          busy,
  output logic          dir_q,
  output logic          mode_q,
  output logic          ev_accept,
  output logic          ev_halt,
  output logic          ev_setup,
  output logic          ev_pulse_end
);

  seq_state_e    state;
  logic          hold_q;
  logic          stop_pend;
  logic [PW-1:0] hi_q, lo_q, ph_q;
  logic [CW-1:0] rem_q;

  assign ev_accept    = (state == ST_IDLE) && op_drive && (count_in != '0)
                        && !(dir_in ? halt_neg : halt_pos);
  assign ev_halt      = op_abort || (dir_q ? halt_neg : halt_pos);
  assign ev_setup     = (state == ST_SETUP);
  assign ev_pulse_end = (state == ST_HIGH) && (ph_q == '0);
  assign pulse_on     = (state == ST_HIGH);
  assign busy         = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      hold_q    <= 1'b0;
      stop_pend <= 1'b0;
      dir_q     <= 1'b0;
      mode_q    <= 1'b0;
      hi_q      <= '0;
      lo_q      <= '0;
      ph_q      <= '0;
      rem_q     <= '0;
    end else begin
      if (op_hold)         hold_q <= 1'b1;
      else if (op_release) hold_q <= 1'b0;

      unique case (state)
        ST_IDLE: begin
          stop_pend <= 1'b0;
          if (ev_accept) begin
            dir_q  <= dir_in;
            mode_q <= mode_in;
            hi_q   <= PW'(high_len(32'(period_in)));
            lo_q   <= PW'(low_len(32'(period_in)));
            rem_q  <= count_in;
            state  <= hold_q ? ST_WAIT : ST_SETUP;
          end
        end
        ST_WAIT: begin
          if (ev_halt)         state <= ST_IDLE;
          else if (op_release) state <= ST_SETUP;
        end
        ST_SETUP: begin
          if (ev_halt) state <= ST_IDLE;
          else begin
            state <= ST_HIGH;
            ph_q  <= hi_q - PW'(1);
          end
        end
        ST_HIGH: begin
          if (ph_q == '0) begin
            rem_q <= rem_q - CW'(1);
            if ((rem_q == CW'(1)) || stop_pend || ev_halt) state <= ST_TAIL;
            else begin
              state <= ST_LOW;
              ph_q  <= lo_q - PW'(1);
            end
          end else begin
            ph_q <= ph_q - PW'(1);
            if (ev_halt) stop_pend <= 1'b1;
          end
        end
        ST_LOW: begin
          if (ev_halt) state <= ST_IDLE;
          else if (ph_q == '0) begin
            state <= ST_HIGH;
            ph_q  <= hi_q - PW'(1);
          end else ph_q <= ph_q - PW'(1);
        end
        ST_TAIL: begin
          stop_pend <= 1'b0;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pulse_outmap.sv
module pulse_outmap (
  input  logic pulse_on,
  input  logic dir_q,
  input  logic mode_q,
  output logic pls_plus,
  output logic pls_minus,
  output logic pls_step,
  output logic dir_out
);

  assign pls_plus  = pulse_on && !mode_q && !dir_q;
  assign pls_minus = pulse_on && !mode_q &&  dir_q;
  assign pls_step  = pulse_on &&  mode_q;
  assign dir_out   = dir_q;

endmodule

// File: rtl/step_pulse_seq.sv
module step_pulse_seq
  import step_pulse_pkg::*;
#(
  parameter int unsigned PW = 16,
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr,
  input  logic [1:0]    host_op,
  input  logic          dir_in,
  input  logic          mode_in,
  input  logic [PW-1:0] period_in,
  input  logic [CW-1:0] count_in,
  input  logic          emg_in,
  input  logic          alarm_in,
  input  logic          lim_pos_in,
  input  logic          lim_neg_in,
  input  logic          lim_halt_en,
  output logic          pls_plus,
  output logic          pls_minus,
  output logic          pls_step,
  output logic          dir_out,
  output logic          busy
);

  localparam int unsigned NSRC = 4;

  logic [NSRC-1:0] src_q;
  logic            halt_any, halt_pos, halt_neg;
  logic            op_drive, op_hold, op_release, op_abort;
  logic            pulse_on, dir_q, mode_q;
  logic            ev_accept, ev_halt, ev_setup, ev_pulse_end;

  assign op_drive   = host_wr && (host_op_e'(host_op) == OP_DRIVE);
  assign op_hold    = host_wr && (host_op_e'(host_op) == OP_HOLD);
  assign op_release = host_wr && (host_op_e'(host_op) == OP_RELEASE);
  assign op_abort   = host_wr && (host_op_e'(host_op) == OP_ABORT);

  stop_qual #(.NSRC(NSRC)) u_qual (
    .clk  (clk),
    .rst_n(rst_n),
    .raw  ({lim_neg_in, lim_pos_in, alarm_in, emg_in}),
    .qual (src_q)
  );

  assign halt_any = src_q[0] | src_q[1];
  assign halt_pos = halt_any | (lim_halt_en & src_q[2]);
  assign halt_neg = halt_any | (lim_halt_en & src_q[3]);

  pulse_engine #(.PW(PW), .CW(CW)) u_eng (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_drive    (op_drive),
    .op_hold     (op_hold),
    .op_release  (op_release),
    .op_abort    (op_abort),
    .dir_in      (dir_in),
    .mode_in     (mode_in),
    .period_in   (period_in),
    .count_in    (count_in),
    .halt_pos    (halt_pos),
    .halt_neg    (halt_neg),
    .pulse_on    (pulse_on),
    .busy        (busy),
    .dir_q       (dir_q),
    .mode_q      (mode_q),
    .ev_accept   (ev_accept),
    .ev_halt     (ev_halt),
    .ev_setup    (ev_setup),
    .ev_pulse_end(ev_pulse_end)
  );

  pulse_outmap u_map (
    .pulse_on (pulse_on),
    .dir_q    (dir_q),
    .mode_q   (mode_q),
    .pls_plus (pls_plus),
    .pls_minus(pls_minus),
    .pls_step (pls_step),
    .dir_out  (dir_out)
  );

endmodule

// File: rtl/step_pulse_seq_chk.sv
module step_pulse_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic pls_plus,
  input logic pls_minus,
  input logic pls_step,
  input logic dir_out,
  input logic busy,
  input logic ev_accept,
  input logic ev_halt,
  input logic ev_setup,
  input logic ev_pulse_end
);

  logic pulse_any;
  assign pulse_any = pls_plus | pls_minus | pls_step;

  // R1: an accepted drive raises busy on the next cycle
  a_r1_busy_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> busy);

  // R2: the setup cycle leads straight into a high pulse unless halted
  a_r2_pulse_after_setup: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_setup && !ev_halt) |=> pulse_any);

  // R5: at most one pulse line is high at a time
  a_r5_one_line: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pls_plus, pls_minus, pls_step}));

  // R6: direction does not move during a move
  a_r6_dir_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(dir_out));

  // R4: a pulse only exists inside a move, and busy outlasts the last pulse
  a_r4_pulse_in_move: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_any |-> busy);
  a_r4_tail_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pulse_end |=> (busy && !pulse_any));

  // R8: no drive is accepted while a move runs
  a_r8_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ev_accept);

  // R9: a halt with no pulse high produces no later pulse
  a_r9_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_halt && !pulse_any) |=> !pulse_any);

endmodule

bind step_pulse_seq step_pulse_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pls_plus    (pls_plus),
  .pls_minus   (pls_minus),
  .pls_step    (pls_step),
  .dir_out     (dir_out),
  .busy        (busy),
  .ev_accept   (ev_accept),
  .ev_halt     (ev_halt),
  .ev_setup    (ev_setup),
  .ev_pulse_end(ev_pulse_end)
);

// File: tb/step_pulse_seq_bench.sv
module step_pulse_seq_bench;
  localparam int PW = 16;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_wr = 1'b0;
  logic [1:0] host_op = 2'd0;
  logic dir_in = 1'b0, mode_in = 1'b0;
  logic [PW-1:0] period_in = 16'd8;
  logic [CW-1:0] count_in = 16'd1;
  logic emg_in = 1'b0, alarm_in = 1'b0, lim_pos_in = 1'b0, lim_neg_in = 1'b0;
  logic lim_halt_en = 1'b0;
  logic pls_plus, pls_minus, pls_step, dir_out, busy;

  always #4 clk = ~clk;

  step_pulse_seq #(.PW(PW), .CW(CW)) u_step_pulse_seq (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_op(host_op),
    .dir_in(dir_in), .mode_in(mode_in), .period_in(period_in), .count_in(count_in),
    .emg_in(emg_in), .alarm_in(alarm_in), .lim_pos_in(lim_pos_in),
    .lim_neg_in(lim_neg_in), .lim_halt_en(lim_halt_en),
    .pls_plus(pls_plus), .pls_minus(pls_minus), .pls_step(pls_step),
    .dir_out(dir_out), .busy(busy)
  );

  typedef struct packed {
    logic [7:0] rq;
    logic busy, pp, pm, st, dr;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  function automatic exp_t mk(int rq, bit b, bit pp, bit pm, bit st, bit dr);
    exp_t e;
    e.rq = rq[7:0]; e.busy = b; e.pp = pp; e.pm = pm; e.st = st; e.dr = dr;
    return e;
  endfunction

  function automatic bit hi(exp_t e);
    return e.pp | e.pm | e.st;
  endfunction

  // Scoreboard driver: expected per-cycle trace of one move, optionally cut by a halt
  task automatic plan_run(int cnt, int per, bit neg, bit m1p, int cut, int rq);
    exp_t b[$];
    int p, h, l, j;
    p = (per < 4) ? 4 : per;
    h = p / 2;
    l = p - h;
    b.push_back(mk(rq, 1, 0, 0, 0, neg));
    for (int k = 0; k < cnt; k++) begin
      for (int c = 0; c < h; c++) b.push_back(mk(rq, 1, !m1p && !neg, !m1p && neg, m1p, neg));
      if (k < cnt - 1) for (int c = 0; c < l; c++) b.push_back(mk(rq, 1, 0, 0, 0, neg));
      else b.push_back(mk(rq, 1, 0, 0, 0, neg));
    end
    if (cut > 0 && cut < b.size()) begin
      if (hi(b[cut-1])) begin
        j = cut;
        while (j < b.size() && hi(b[j])) j++;
        b = b[0:j-1];
        b.push_back(mk(rq, 1, 0, 0, 0, neg));
      end else b = b[0:cut-1];
    end
    b.push_back(mk(rq, 0, 0, 0, 0, 0));
    foreach (b[i]) q.push_back(b[i]);
  endtask

  task automatic push_idle(int n, int rq);
    for (int i = 0; i < n; i++) q.push_back(mk(rq, 0, 0, 0, 0, 0));
  endtask

  // Monitor: compares each sampled cycle with the next expected item
  always @(posedge clk) begin
    exp_t e;
    logic [4:0] act, expv;
    #2;
    if (q.size() != 0) begin
      e = q.pop_front();
      act  = {busy, pls_plus, pls_minus, pls_step, e.busy ? dir_out : 1'b0};
      expv = {e.busy, e.pp, e.pm, e.st, e.busy ? e.dr : 1'b0};
      checks++;
      if (act !== expv) begin
        fails++;
        $display("FAIL R%0d busy/plus/minus/step/dir actual=%b expected=%b at %0t",
                 e.rq, act, expv, $time);
      end
    end
  end

  task automatic direct(string rq, logic [4:0] act, logic [4:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", rq, act, expv);
    end
  endtask

  task automatic wr(logic [1:0] op);
    host_op = op;
    host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic setmove(int cnt, int per, bit neg, bit m1p);
    count_in = CW'(cnt); period_in = PW'(per); dir_in = neg; mode_in = m1p;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog all-requirements actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    // R12: outputs idle during reset
    repeat (3) @(negedge clk);
    direct("R12 in reset", {busy, pls_plus, pls_minus, pls_step, dir_out}, 5'b0);
    rst_n = 1'b1;
    @(negedge clk);
    direct("R12 after reset", {busy, pls_plus, pls_minus, pls_step, dir_out}, 5'b0);

    // R1 R2 R3 R4 R5: plus line, three pulses, period 8
    setmove(3, 8, 0, 0); plan_run(3, 8, 0, 0, 0, 2); wr(2'd0); drain();
    // R3 R5: minus line, odd period 9
    setmove(2, 9, 1, 0); plan_run(2, 9, 1, 0, 0, 5); wr(2'd0); drain();
    // R6: step + direction, negative
    setmove(2, 5, 1, 1); plan_run(2, 5, 1, 1, 0, 6); wr(2'd0); drain();
    // R6: step + direction, positive
    setmove(3, 4, 0, 1); plan_run(3, 4, 0, 1, 0, 6); wr(2'd0); drain();
    // R3: period below minimum is clamped to 4
    setmove(2, 3, 0, 0); plan_run(2, 3, 0, 0, 0, 3); wr(2'd0); drain();
    // R4: zero count ignored
    setmove(0, 8, 0, 0); push_idle(4, 4); wr(2'd0); drain();

    // R8: drive while busy ignored
    setmove(3, 6, 0, 0); plan_run(3, 6, 0, 0, 0, 8); wr(2'd0);
    repeat (3) @(negedge clk);
    setmove(7, 4, 1, 1); wr(2'd0);
    drain();

    // R7: hold gate, then release
    wr(2'd1);
    setmove(2, 6, 1, 0);
    for (int i = 0; i < 5; i++) q.push_back(mk(7, 1, 0, 0, 0, 1));
    wr(2'd0);
    repeat (4) @(negedge clk);
    plan_run(2, 6, 1, 0, 0, 7);
    wr(2'd2);
    drain();
    // R7: hold released, next drive starts at once
    setmove(1, 4, 0, 0); plan_run(1, 4, 0, 0, 0, 7); wr(2'd0); drain();

    // R9: abort while a pulse is high
    setmove(4, 8, 0, 0); plan_run(4, 8, 0, 0, 3, 9); wr(2'd0);
    repeat (2) @(negedge clk); wr(2'd3); drain();
    // R9: abort during the low phase
    setmove(4, 8, 1, 1); plan_run(4, 8, 1, 1, 6, 9); wr(2'd0);
    repeat (5) @(negedge clk); wr(2'd3); drain();

    // R10: emergency qualified for two cycles, halt at sample 7 (low phase)
    setmove(5, 8, 0, 0); plan_run(5, 8, 0, 0, 7, 10); wr(2'd0);
    repeat (4) @(negedge clk); emg_in = 1'b1;
    repeat (2) @(negedge clk); emg_in = 1'b0;
    drain();
    // R10: one-cycle alarm glitch ignored
    setmove(3, 6, 0, 0); plan_run(3, 6, 0, 0, 0, 10); wr(2'd0);
    repeat (2) @(negedge clk); alarm_in = 1'b1;
    @(negedge clk); alarm_in = 1'b0;
    drain();
    // R10: limit facing away from travel has no effect
    lim_halt_en = 1'b1; lim_neg_in = 1'b1;
    repeat (3) @(negedge clk);
    setmove(2, 6, 0, 0); plan_run(2, 6, 0, 0, 0, 10); wr(2'd0); drain();
    lim_neg_in = 1'b0;
    // R10: positive limit halts at the end of a high phase (sample 4)
    setmove(3, 6, 0, 0); plan_run(3, 6, 0, 0, 4, 10); wr(2'd0);
    repeat (1) @(negedge clk); lim_pos_in = 1'b1;
    repeat (2) @(negedge clk); lim_pos_in = 1'b0;
    drain();
    // R10: limit ignored when limit halting is disabled
    lim_halt_en = 1'b0; lim_pos_in = 1'b1;
    setmove(2, 4, 0, 0); plan_run(2, 4, 0, 0, 0, 10); wr(2'd0); drain();
    lim_pos_in = 1'b0;

    // R11: drive refused while emergency is qualified
    emg_in = 1'b1;
    repeat (3) @(negedge clk);
    setmove(2, 4, 0, 0); push_idle(4, 11); wr(2'd0); drain();
    emg_in = 1'b0;
    repeat (3) @(negedge clk);
    // R11: same drive accepted once the source clears
    plan_run(2, 4, 0, 0, 0, 11); wr(2'd0); drain();

    done = 1'b1;
    finish_run();
  end
endmodule